// File: doc/BRIEF.md
# Accumulator Execute Unit

This block is the register-to-register execution stage of a 16-bit load–store processor. It holds four general accumulators and a single carry bit. Each instruction it receives names a source and a destination accumulator. It also carries a function code, a carry-setup field, a shift field, a skip-test field and a flag that discards the result. Within one clock cycle the unit takes several steps. It forms the carry base and runs the function. It shifts or rotates the 17-bit carry-and-result word. It then evaluates the skip test on that shifted word. Finally it writes the destination and the carry, unless the discard flag is raised.

The instruction sequencer raises the execute strobe for one cycle per instruction. On the following cycle it reads the skip flag to decide whether to step over the next instruction. Accumulators 2 and 3 are driven out continuously, so address generation can use them as index registers. The registered result bus shows the shifted value of the most recent instruction, whether or not that value was stored.

Top module: `acc_exec_unit`

## Requirements
- R1: After reset, all accumulators, the carry, the result bus and the skip flag are zero.
- R2: The function codes are 0 complement (~S), 1 negate (-S), 2 move (S), 3 increment (S+1), 4 add-complement (D+~S), 5 subtract (D-S), 6 add (S+D) and 7 AND (S&D). For codes 1, 3, 4, 5 and 6, a carry out of bit 15 of the 17-bit sum (~S+1, S+1, D+~S, D+~S+1, S+D) inverts the carry base. For codes 0, 2 and 7 the carry base passes through unchanged.
- R3: S is the source accumulator and D is the destination accumulator, both read before the update. The result goes to the destination. The behaviour is the same when source equals destination.
- R4: The carry setup field sets the carry base before the function. The codes are 0 keep the current carry, 1 force 0, 2 force 1, and 3 invert the current carry.
- R5: The shift field acts on the 17-bit word {carry, result}. The codes are 0 none, 1 rotate left through the carry (new carry = result bit 15, new bit 0 = old carry), 2 rotate right through the carry (new carry = result bit 0, new bit 15 = old carry), and 3 swap the result bytes with the carry unchanged.
- R6: The skip test is evaluated on the shifted carry and result. The codes are 0 never, 1 always, 2 carry is 0, 3 carry is 1, 4 result is zero, 5 result is nonzero, 6 carry is 0 or result is zero, and 7 carry is 1 and result is nonzero. The skip output is high for exactly the one cycle that follows the execute strobe.
- R7: With the discard flag set, neither the accumulators nor the carry change. The result bus and the skip output still reflect the instruction.
- R8: Without the execute strobe no state changes and the skip output is low. An executed instruction changes only its destination accumulator.
- R9: The two index outputs always show accumulators 2 and 3.
- R10: After each executed instruction, the result bus holds the shifted result until the next executed instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_i | input | 1 | Execute strobe, one cycle per instruction |
| src_i | input | 2 | Source accumulator index |
| dst_i | input | 2 | Destination accumulator index |
| fn_i | input | 3 | Function code |
| cyc_i | input | 2 | Carry setup code |
| sh_i | input | 2 | Shift code |
| skp_i | input | 3 | Skip test code |
| nold_i | input | 1 | Discard result when high |
| res_o | output | 16 | Shifted result of the last executed instruction |
| carry_o | output | 1 | Carry register |
| skip_o | output | 1 | Skip flag, valid the cycle after execute |
| idx2_o | output | 16 | Accumulator 2 |
| idx3_o | output | 16 | Accumulator 3 |

## Verification
Some properties are checked by the assertions on every cycle. Idle cycles leave the accumulators, the carry and the skip flag untouched. The discard flag freezes the stored state. An instruction never disturbs accumulators other than its destination. The never and always skip tests resolve as coded. The logical functions and byte swap leave the carry base intact. Everything arithmetic has to come from the directed scenarios, which compare every instruction against a model written from the requirements. That covers the sums and their carry-outs, the carry setup, the rotate paths, the remaining skip tests and the case where source equals destination.

// File: rtl/acc_pkg.sv
package acc_pkg;

    typedef enum logic [2:0] {
        FN_COM = 3'd0,
        FN_NEG = 3'd1,
        FN_MOV = 3'd2,
        FN_INC = 3'd3,
        FN_ADC = 3'd4,
        FN_SUB = 3'd5,
        FN_ADD = 3'd6,
        FN_AND = 3'd7
    } fn_e;

    typedef enum logic [1:0] {
        CY_KEEP = 2'd0,
        CY_ZERO = 2'd1,
        CY_ONE  = 2'd2,
        CY_FLIP = 2'd3
    } cyc_e;

    typedef enum logic [1:0] {
        SH_NONE = 2'd0,
        SH_ROL  = 2'd1,
        SH_ROR  = 2'd2,
        SH_SWAP = 2'd3
    } sh_e;

    typedef enum logic [2:0] {
        SK_NEVER  = 3'd0,
        SK_ALWAYS = 3'd1,
        SK_CZ     = 3'd2,
        SK_CN     = 3'd3,
        SK_RZ     = 3'd4,
        SK_RN     = 3'd5,
        SK_EITHER = 3'd6,
        SK_BOTH   = 3'd7
    } skp_e;

endpackage

// File: rtl/acc_alu.sv
module acc_alu
    import acc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] s_i,
    input  logic [W-1:0] d_i,
    input  fn_e          fn_i,
    input  cyc_e         cyc_i,
    input  logic         cy_i,
    output logic [W-1:0] r_o,
    output logic         cy_o
);
    logic         base;
    logic [W-1:0] op_a;
    logic [W-1:0] op_b;
    logic         cin;
    logic         arith;
    logic [W:0]   sum;

    always_comb begin
        unique case (cyc_i)
            CY_KEEP: base = cy_i;
            CY_ZERO: base = 1'b0;
            CY_ONE:  base = 1'b1;
            default: base = ~cy_i;
        endcase
    end

    always_comb begin
        op_a  = s_i;
        op_b  = '0;
        cin   = 1'b0;
        arith = 1'b1;
        unique case (fn_i)
            FN_COM: begin op_a = ~s_i; arith = 1'b0; end
            FN_NEG: begin op_a = ~s_i; cin = 1'b1; end
            FN_MOV: begin arith = 1'b0; end
            FN_INC: begin cin = 1'b1; end
            FN_ADC: begin op_a = ~s_i; op_b = d_i; end
            FN_SUB: begin op_a = ~s_i; op_b = d_i; cin = 1'b1; end
            FN_ADD: begin op_b = d_i; end
            default: begin arith = 1'b0; end
        endcase
        sum = {1'b0, op_a} + {1'b0, op_b} + {{W{1'b0}}, cin};
    end

    always_comb begin
        r_o  = (fn_i == FN_AND) ? (s_i & d_i) : sum[W-1:0];
        cy_o = base ^ (arith & sum[W]);
    end

    always_comb begin
        if (fn_i == FN_MOV || fn_i == FN_AND || fn_i == FN_COM) begin
            assert_logic_keeps_base_R2: assert (cy_o == base);
        end
    end

endmodule

// File: rtl/acc_shift.sv
module acc_shift
    import acc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] r_i,
    input  logic         c_i,
    input  sh_e          sh_i,
    output logic [W-1:0] r_o,
    output logic         c_o
);
    localparam int HALF = W / 2;

    always_comb begin
        r_o = r_i;
        c_o = c_i;
        unique case (sh_i)
            SH_NONE: ;
            SH_ROL: begin
                r_o = {r_i[W-2:0], c_i};
                c_o = r_i[W-1];
            end
            SH_ROR: begin
                r_o = {c_i, r_i[W-1:1]};
                c_o = r_i[0];
            end
            default: r_o = {r_i[HALF-1:0], r_i[W-1:HALF]};
        endcase
    end

    always_comb begin
        if (sh_i == SH_SWAP) begin
            assert_swap_keeps_carry_R5: assert (c_o == c_i);
        end
    end

endmodule

// File: rtl/acc_skip.sv
module acc_skip
    import acc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] r_i,
    input  logic         c_i,
    input  skp_e         sel_i,
    output logic         take_o
);
    logic rz;

    always_comb begin
        rz = (r_i == '0);
        unique case (sel_i)
            SK_NEVER:  take_o = 1'b0;
            SK_ALWAYS: take_o = 1'b1;
            SK_CZ:     take_o = ~c_i;
            SK_CN:     take_o = c_i;
            SK_RZ:     take_o = rz;
            SK_RN:     take_o = ~rz;
            SK_EITHER: take_o = ~c_i | rz;
            default:   take_o = c_i & ~rz;
        endcase
    end

endmodule

// File: rtl/acc_exec_unit.sv
module acc_exec_unit
    import acc_pkg::*;
#(
    parameter int W    = 16,
    parameter int NACC = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     exec_i,
    input  logic [$clog2(NACC)-1:0]  src_i,
    input  logic [$clog2(NACC)-1:0]  dst_i,
    input  logic [2:0]               fn_i,
    input  logic [1:0]               cyc_i,
    input  logic [1:0]               sh_i,
    input  logic [2:0]               skp_i,
    input  logic                     nold_i,
    output logic [W-1:0]             res_o,
    output logic                     carry_o,
    output logic                     skip_o,
    output logic [W-1:0]             idx2_o,
    output logic [W-1:0]             idx3_o
);
    localparam int IW = $clog2(NACC);

    typedef struct packed {
        logic [NACC-1:0][W-1:0] acc;
        logic                   cy;
        logic [W-1:0]           res;
        logic                   skip;
    } st_t;

    st_t st_d, st_q;

    logic [W-1:0] opnd_s, opnd_d, alu_r, sh_r;
    logic         alu_c, sh_c, take;

    assign opnd_s = st_q.acc[src_i];
    assign opnd_d = st_q.acc[dst_i];

    acc_alu #(.W(W)) u_alu (
        .s_i   (opnd_s),
        .d_i   (opnd_d),
        .fn_i  (fn_e'(fn_i)),
        .cyc_i (cyc_e'(cyc_i)),
        .cy_i  (st_q.cy),
        .r_o   (alu_r),
        .cy_o  (alu_c)
    );

    acc_shift #(.W(W)) u_shift (
        .r_i  (alu_r),
        .c_i  (alu_c),
        .sh_i (sh_e'(sh_i)),
        .r_o  (sh_r),
        .c_o  (sh_c)
    );

    acc_skip #(.W(W)) u_skip (
        .r_i    (sh_r),
        .c_i    (sh_c),
        .sel_i  (skp_e'(skp_i)),
        .take_o (take)
    );

    always_comb begin
        st_d      = st_q;
        st_d.skip = 1'b0;
        if (exec_i) begin
            st_d.res  = sh_r;
            st_d.skip = take;
            if (!nold_i) begin
                st_d.acc[dst_i] = sh_r;
                st_d.cy         = sh_c;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_o   = st_q.res;
    assign carry_o = st_q.cy;
    assign skip_o  = st_q.skip;
    assign idx2_o  = st_q.acc[2];
    assign idx3_o  = st_q.acc[3];

    assert_idle_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_i |=> ($stable(st_q.acc) && $stable(carry_o) && !skip_o));

    assert_discard_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && nold_i) |=> ($stable(st_q.acc) && $stable(carry_o)));

    assert_skip_never_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && skp_i == 3'd0) |=> !skip_o);

    assert_skip_always_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && skp_i == 3'd1) |=> skip_o);

    for (genvar k = 0; k < NACC; k++) begin : g_only_dst
        assert_only_dst_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (exec_i && dst_i != IW'(k)) |=> $stable(st_q.acc[k]));
    end

endmodule

// File: tb/acc_exec_unit_bench.sv
module acc_exec_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exec_i = 1'b0;
    logic [1:0]  src_i = '0, dst_i = '0, cyc_i = '0, sh_i = '0;
    logic [2:0]  fn_i = '0, skp_i = '0;
    logic        nold_i = 1'b0;
    logic [15:0] res_o, idx2_o, idx3_o;
    logic        carry_o, skip_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [15:0] m_acc [4];
    logic        m_c;
    logic [15:0] m_res;

    always #2 clk = ~clk;

    acc_exec_unit u_acc_exec_unit (
        .clk, .rst_n, .exec_i, .src_i, .dst_i, .fn_i, .cyc_i, .sh_i,
        .skp_i, .nold_i, .res_o, .carry_o, .skip_o, .idx2_o, .idx3_o
    );

    task automatic chk(string req, string what, logic [16:0] act, logic [16:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Runs one instruction against the model and compares every output.
    task automatic op(string req, logic [1:0] s, logic [1:0] d, logic [2:0] f,
                      logic [1:0] cc, logic [1:0] sh, logic [2:0] sk, logic nl);
        logic [15:0] sv, dv, r;
        logic [16:0] t;
        logic k, b, c, rz, e_skip;
        sv = m_acc[s]; dv = m_acc[d]; k = 1'b0;
        case (f)
            3'd0: r = ~sv;
            3'd1: begin r = 16'd0 - sv; k = (sv == 16'd0); end
            3'd2: r = sv;
            3'd3: begin r = sv + 16'd1; k = (sv == 16'hFFFF); end
            3'd4: begin t = {1'b0, dv} + {1'b0, ~sv}; r = t[15:0]; k = t[16]; end
            3'd5: begin r = dv - sv; k = (dv >= sv); end
            3'd6: begin t = {1'b0, sv} + {1'b0, dv}; r = t[15:0]; k = t[16]; end
            default: r = sv & dv;
        endcase
        case (cc)
            2'd0: b = m_c;
            2'd1: b = 1'b0;
            2'd2: b = 1'b1;
            default: b = ~m_c;
        endcase
        c = b ^ k;
        case (sh)
            2'd1: {c, r} = {r, c};
            2'd2: {r, c} = {c, r};
            2'd3: r = {r[7:0], r[15:8]};
            default: ;
        endcase
        rz = (r == 16'd0);
        case (sk)
            3'd0: e_skip = 1'b0;
            3'd1: e_skip = 1'b1;
            3'd2: e_skip = !c;
            3'd3: e_skip = c;
            3'd4: e_skip = rz;
            3'd5: e_skip = !rz;
            3'd6: e_skip = !c || rz;
            default: e_skip = c && !rz;
        endcase
        m_res = r;
        if (!nl) begin m_acc[d] = r; m_c = c; end
        @(negedge clk);
        exec_i = 1'b1; src_i = s; dst_i = d; fn_i = f; cyc_i = cc;
        sh_i = sh; skp_i = sk; nold_i = nl;
        @(negedge clk);
        exec_i = 1'b0;
        chk(req, "result", {1'b0, res_o}, {1'b0, m_res});
        chk(req, "carry",  {16'd0, carry_o}, {16'd0, m_c});
        chk(req, "skip",   {16'd0, skip_o}, {16'd0, e_skip});
        chk("R9", "index2", {1'b0, idx2_o}, {1'b0, m_acc[2]});
        chk("R9", "index3", {1'b0, idx3_o}, {1'b0, m_acc[3]});
    endtask

    // Reads an accumulator through a discarded move.
    task automatic peek(string req, logic [1:0] a);
        op(req, a, a, 3'd2, 2'd0, 2'd0, 3'd4, 1'b1);
    endtask

    // Builds a constant by doubling and incrementing.
    task automatic load(logic [1:0] a, logic [15:0] v);
        op("R3", a, a, 3'd5, 2'd0, 2'd0, 3'd0, 1'b0);
        for (int i = 15; i >= 0; i--) begin
            op("R2", a, a, 3'd6, 2'd0, 2'd0, 3'd0, 1'b0);
            if (v[i]) op("R2", a, a, 3'd3, 2'd0, 2'd0, 3'd0, 1'b0);
        end
    endtask

    task automatic t_reset;
        chk("R1", "result", {1'b0, res_o}, 17'd0);
        chk("R1", "carry",  {16'd0, carry_o}, 17'd0);
        chk("R1", "skip",   {16'd0, skip_o}, 17'd0);
        chk("R1", "index2", {1'b0, idx2_o}, 17'd0);
        chk("R1", "index3", {1'b0, idx3_o}, 17'd0);
        for (int a = 0; a < 4; a++) peek("R1", 2'(a));
    endtask

    task automatic t_index;
        load(2'd2, 16'h1234);
        load(2'd3, 16'hF00D);
        chk("R9", "index2 literal", {1'b0, idx2_o}, 17'h01234);
        chk("R9", "index3 literal", {1'b0, idx3_o}, 17'h0F00D);
        load(2'd0, 16'h8001);
        load(2'd1, 16'h00FF);
    endtask

    task automatic t_functions;
        for (int f = 0; f < 8; f++) begin
            op("R2", 2'd2, 2'd1, 3'(f), 2'd0, 2'd0, 3'd0, 1'b1);
            op("R2", 2'd3, 2'd0, 3'(f), 2'd1, 2'd0, 3'd0, 1'b1);
        end
        // literal: 0xFFFF + 1 flips a cleared base
        load(2'd1, 16'hFFFF);
        load(2'd0, 16'h0001);
        op("R2", 2'd0, 2'd1, 3'd6, 2'd1, 2'd0, 3'd0, 1'b0);
        chk("R2", "add wrap carry", {16'd0, carry_o}, 17'd1);
        chk("R2", "add wrap result", {1'b0, res_o}, 17'd0);
        op("R2", 2'd0, 2'd0, 3'd1, 2'd1, 2'd0, 3'd0, 1'b0);
        for (int f = 0; f < 8; f++)
            op("R3", 2'd2, 2'd2, 3'(f), 2'd0, 2'd0, 3'd0, 1'b0);
        load(2'd2, 16'h1234);
        op("R3", 2'd3, 2'd2, 3'd6, 2'd0, 2'd0, 3'd0, 1'b0);
        op("R3", 2'd3, 2'd3, 3'd5, 2'd0, 2'd0, 3'd0, 1'b0);
        op("R3", 2'd1, 2'd0, 3'd4, 2'd0, 2'd0, 3'd0, 1'b0);
    endtask

    task automatic t_carry;
        load(2'd1, 16'h4321);
        for (int c = 0; c < 4; c++) begin
            op("R4", 2'd1, 2'd0, 3'd2, 2'(c), 2'd0, 3'd3, 1'b0);
            op("R4", 2'd1, 2'd0, 3'd6, 2'(c), 2'd0, 3'd3, 1'b0);
        end
    endtask

    task automatic t_shift;
        load(2'd1, 16'h8421);
        for (int s = 0; s < 4; s++) begin
            op("R5", 2'd1, 2'd1, 3'd2, 2'd2, 2'(s), 3'd0, 1'b0);
            op("R5", 2'd1, 2'd1, 3'd2, 2'd1, 2'(s), 3'd0, 1'b0);
        end
        load(2'd0, 16'h12AB);
        op("R5", 2'd0, 2'd0, 3'd2, 2'd2, 2'd3, 3'd0, 1'b0);
        chk("R5", "swap literal", {1'b0, res_o}, 17'h0AB12);
        op("R5", 2'd0, 2'd0, 3'd2, 2'd1, 2'd2, 3'd0, 1'b0);
        chk("R5", "ror literal", {1'b0, res_o}, 17'h05589);
        chk("R5", "ror carry", {16'd0, carry_o}, 17'd0);
    endtask

    task automatic t_skip;
        load(2'd0, 16'h0000);
        load(2'd1, 16'h0040);
        for (int k = 0; k < 8; k++) begin
            op("R6", 2'd0, 2'd2, 3'd2, 2'd1, 2'd0, 3'(k), 1'b1);
            op("R6", 2'd0, 2'd2, 3'd2, 2'd2, 2'd0, 3'(k), 1'b1);
            op("R6", 2'd1, 2'd2, 3'd2, 2'd1, 2'd0, 3'(k), 1'b1);
            op("R6", 2'd1, 2'd2, 3'd2, 2'd2, 2'd0, 3'(k), 1'b1);
            op("R6", 2'd1, 2'd2, 3'd2, 2'd2, 2'd2, 3'(k), 1'b1);
        end
        @(negedge clk);
        chk("R6", "skip one cycle", {16'd0, skip_o}, 17'd0);
    endtask

    task automatic t_noload;
        for (int f = 0; f < 8; f++)
            op("R7", 2'd1, 2'd3, 3'(f), 2'd3, 2'd1, 3'd1, 1'b1);
        for (int a = 0; a < 4; a++) peek("R7", 2'(a));
    endtask

    task automatic t_idle;
        logic [15:0] r0;
        r0 = res_o;
        @(negedge clk);
        src_i = 2'd1; dst_i = 2'd2; fn_i = 3'd6; cyc_i = 2'd3; sh_i = 2'd1;
        skp_i = 3'd1; nold_i = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8", "idle skip",   {16'd0, skip_o}, 17'd0);
        chk("R8", "idle carry",  {16'd0, carry_o}, {16'd0, m_c});
        chk("R10", "idle result", {1'b0, res_o}, {1'b0, r0});
        for (int a = 0; a < 4; a++) peek("R8", 2'(a));
        op("R8", 2'd0, 2'd1, 3'd3, 2'd0, 2'd0, 3'd0, 1'b0);
        for (int a = 0; a < 4; a++) peek("R10", 2'(a));
    endtask

    initial begin
        for (int a = 0; a < 4; a++) m_acc[a] = 16'd0;
        m_c = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_index();
        t_functions();
        t_carry();
        t_shift();
        t_skip();
        t_noload();
        t_idle();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule